// File: doc/BRIEF.md
# Floppy Drive Timing Generator

This block times the three drive-control delays of a floppy disk controller. The first is the spacing of step pulses during a seek. The second is the wait after the head is loaded before a transfer may begin. The third is the wait after a transfer ends before the head is unloaded. A parameter load delivers three codes, and a separate two-bit input selects the data rate. Every delay is counted in rate-dependent units that are derived from a fixed-period `tick_i` input. The same delays apply to both recording encodings.

The controller uses three inputs to start the timers. It issues a step request with a direction and a pulse count. It raises `head_load_i` and waits for `head_ready_o`. It pulses `rw_end_i` at the end of a transfer and receives `head_unload_o` once the unload delay has run out.

Each timer takes a snapshot of its load value and rate scale when it starts. A parameter load or a rate change therefore only affects the next start.

Top module: `fdt_drive_timing`

## Requirements
- R1: After reset every output is low and the stored codes are zero, so the step interval is 16 units.
- R2: A parameter load with `spec_nd_i`=0 stores the three codes. With `spec_nd_i`=1 the codes stay unchanged and `spec_err_o` is high for exactly the cycle after the load.
- R3: The unit length in ticks follows `rate_i`: 00 gives 2 ticks, 10 gives 4 ticks and 11 gives 1 tick. For 01 the k-th unit after a timer start ends on tick ceil(10k/3).
- R4: Adjacent step pulses are spaced by (16 − S) units, where S is the 4-bit step code.
- R5: A step request with count C>0 produces exactly C one-cycle pulses on `step_o`, the first one in the cycle after the request. `step_dir_o` holds the requested direction. `step_done_o` pulses one step interval after the last pulse.
- R6: A step request with C=0 pulses `step_done_o` in the next cycle and produces no step pulse. A step request made while `step_busy_o` is high is ignored.
- R7: `head_ready_o` rises 2·L units after `head_load_i` rises, where L is the 7-bit load code and L=0 means 256 units. It falls the cycle after `head_load_i` falls. A fall before the delay ends abandons the count.
- R8: `head_unload_o` pulses for one cycle 16·U units after `rw_end_i`, where U is the 4-bit unload code and U=0 means 256 units. A new `rw_end_i` restarts the count. A rising `head_load_i` cancels a pending unload.
- R9: A parameter load or a change of `rate_i` while a delay is running leaves that delay unchanged. The new values apply from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base time tick, one cycle wide |
| rate_i | input | 2 | Data rate select (00/01/10/11) |
| spec_we_i | input | 1 | Parameter load strobe |
| spec_nd_i | input | 1 | Non-DMA request bit, must be 0 |
| spec_srt_i | input | 4 | Step interval code |
| spec_hlt_i | input | 7 | Head load delay code |
| spec_hut_i | input | 4 | Head unload delay code |
| spec_err_o | output | 1 | Unsupported parameter load flag |
| step_req_i | input | 1 | Step request strobe |
| step_dir_i | input | 1 | Requested step direction |
| step_cnt_i | input | STEP_CNT_W | Requested number of pulses |
| step_o | output | 1 | Step pulse |
| step_dir_o | output | 1 | Direction of the current seek |
| step_busy_o | output | 1 | Seek in progress |
| step_done_o | output | 1 | Seek finished strobe |
| head_load_i | input | 1 | Head load level |
| head_ready_o | output | 1 | Head settled, transfer may start |
| rw_end_i | input | 1 | End-of-transfer strobe |
| head_unload_o | output | 1 | Head unload event |

## Verification
The hardest case to reach is a change of rate and codes in the middle of a running count. Two delays must be checked from the ports: the one already running, which must keep its old value, and the one after it, which must use the new value. The stimulus loads a 10-code head delay at the fastest rate and raises the head load. A few cycles later it switches to the slowest rate and loads a larger code. It checks that the running delay still ends after 20 ticks. It then drops and raises the head load and expects 400 ticks. The 300 kbps case is reached by measuring every delay at rate code 01 against the ceil(10k/3) tick schedule. For the maximum delays, both load codes are set to zero at every rate.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  localparam int SRT_W   = 4;
  localparam int HLT_W   = 7;
  localparam int HUT_W   = 4;
  localparam int CNT_W   = 9;
  localparam int SCALE_W = 4;

  typedef enum logic [1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rate_e;

  // unit length = num/den ticks
  typedef struct packed {
    logic [SCALE_W-1:0] num;
    logic [SCALE_W-1:0] den;
  } scale_t;

  function automatic scale_t rate_scale(input logic [1:0] r);
    scale_t s;
    case (rate_e'(r))
      RATE_500K: s = '{num: 4'd2,  den: 4'd1};
      RATE_300K: s = '{num: 4'd10, den: 4'd3};
      RATE_250K: s = '{num: 4'd4,  den: 4'd1};
      default:   s = '{num: 4'd1,  den: 4'd1};
    endcase
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] srt_units(input logic [SRT_W-1:0] n);
    return CNT_W'(16) - {{(CNT_W-SRT_W){1'b0}}, n};
  endfunction

  function automatic logic [CNT_W-1:0] hlt_units(input logic [HLT_W-1:0] n);
    return (n == '0) ? CNT_W'(256) : {1'b0, n, 1'b0};
  endfunction

  function automatic logic [CNT_W-1:0] hut_units(input logic [HUT_W-1:0] n);
    return (n == '0) ? CNT_W'(256) : {1'b0, n, 4'b0000};
  endfunction
endpackage

// File: rtl/fdt_prescaled_timer.sv
module fdt_prescaled_timer
  import fdt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   load_i,
  input  scale_t             scale_i,
  output logic               busy_o,
  output logic               expire_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [SCALE_W-1:0] acc_q;
  scale_t             scale_q;
  logic               run_q, exp_q;
  logic [SCALE_W:0]   sum, rem;
  logic               unit;

  // fractional prescaler: unit ends when accumulated den reaches num
  assign sum  = {1'b0, acc_q} + {1'b0, scale_q.den};
  assign rem  = sum - {1'b0, scale_q.num};
  assign unit = sum >= {1'b0, scale_q.num};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      scale_q <= '0;
      run_q   <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (start_i) begin
        cnt_q   <= load_i;
        acc_q   <= '0;
        scale_q <= scale_i;
        run_q   <= 1'b1;
      end else if (abort_i) begin
        run_q <= 1'b0;
      end else if (run_q && tick_i) begin
        if (unit) begin
          acc_q <= rem[SCALE_W-1:0];
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            run_q <= 1'b0;
            exp_q <= 1'b1;
          end
        end else begin
          acc_q <= sum[SCALE_W-1:0];
        end
      end
    end
  end

  assign busy_o   = run_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/fdt_step_ctrl.sv
module fdt_step_ctrl #(
  parameter int STEP_CNT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  dir_i,
  input  logic [STEP_CNT_W-1:0] cnt_i,
  input  logic                  tmr_exp_i,
  output logic                  tmr_start_o,
  output logic                  step_o,
  output logic                  dir_o,
  output logic                  busy_o,
  output logic                  done_o
);
  logic                  busy_q, step_q, dir_q, done_q;
  logic [STEP_CNT_W-1:0] rem_q;
  logic                  accept, more;

  assign accept      = req_i && !busy_q;
  assign more        = busy_q && tmr_exp_i && (rem_q != '0);
  assign tmr_start_o = (accept && (cnt_i != '0)) || more;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      step_q <= 1'b0;
      done_q <= 1'b0;
      if (accept) begin
        dir_q <= dir_i;
        if (cnt_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          step_q <= 1'b1;
          rem_q  <= cnt_i - 1'b1;
        end
      end else if (more) begin
        step_q <= 1'b1;
        rem_q  <= rem_q - 1'b1;
      end else if (busy_q && tmr_exp_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign step_o = step_q;
  assign dir_o  = dir_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/fdt_drive_timing.sv
module fdt_drive_timing
  import fdt_pkg::*;
#(
  parameter int STEP_CNT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [1:0]            rate_i,
  input  logic                  spec_we_i,
  input  logic                  spec_nd_i,
  input  logic [SRT_W-1:0]      spec_srt_i,
  input  logic [HLT_W-1:0]      spec_hlt_i,
  input  logic [HUT_W-1:0]      spec_hut_i,
  output logic                  spec_err_o,
  input  logic                  step_req_i,
  input  logic                  step_dir_i,
  input  logic [STEP_CNT_W-1:0] step_cnt_i,
  output logic                  step_o,
  output logic                  step_dir_o,
  output logic                  step_busy_o,
  output logic                  step_done_o,
  input  logic                  head_load_i,
  output logic                  head_ready_o,
  input  logic                  rw_end_i,
  output logic                  head_unload_o
);
  logic [SRT_W-1:0] srt_q;
  logic [HLT_W-1:0] hlt_q;
  logic [HUT_W-1:0] hut_q;
  logic             err_q, hl_q, ready_q;
  logic             load_rise;
  logic             srt_start, srt_exp, hlt_exp;
  logic             srt_busy, hlt_busy, hut_busy;
  scale_t           scale;

  assign scale     = rate_scale(rate_i);
  assign load_rise = head_load_i && !hl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srt_q   <= '0;
      hlt_q   <= '0;
      hut_q   <= '0;
      err_q   <= 1'b0;
      hl_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      err_q <= spec_we_i && spec_nd_i;
      if (spec_we_i && !spec_nd_i) begin
        srt_q <= spec_srt_i;
        hlt_q <= spec_hlt_i;
        hut_q <= spec_hut_i;
      end
      hl_q <= head_load_i;
      if (!head_load_i)  ready_q <= 1'b0;
      else if (hlt_exp)  ready_q <= 1'b1;
    end
  end

  fdt_step_ctrl #(.STEP_CNT_W(STEP_CNT_W)) i_step_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (step_req_i),
    .dir_i       (step_dir_i),
    .cnt_i       (step_cnt_i),
    .tmr_exp_i   (srt_exp),
    .tmr_start_o (srt_start),
    .step_o      (step_o),
    .dir_o       (step_dir_o),
    .busy_o      (step_busy_o),
    .done_o      (step_done_o)
  );

  fdt_prescaled_timer i_srt_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (srt_start),
    .abort_i  (1'b0),
    .tick_i   (tick_i),
    .load_i   (srt_units(srt_q)),
    .scale_i  (scale),
    .busy_o   (srt_busy),
    .expire_o (srt_exp)
  );

  fdt_prescaled_timer i_hlt_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (load_rise),
    .abort_i  (!head_load_i),
    .tick_i   (tick_i),
    .load_i   (hlt_units(hlt_q)),
    .scale_i  (scale),
    .busy_o   (hlt_busy),
    .expire_o (hlt_exp)
  );

  fdt_prescaled_timer i_hut_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (rw_end_i),
    .abort_i  (load_rise),
    .tick_i   (tick_i),
    .load_i   (hut_units(hut_q)),
    .scale_i  (scale),
    .busy_o   (hut_busy),
    .expire_o (head_unload_o)
  );

  assign spec_err_o   = err_q;
  assign head_ready_o = ready_q;
endmodule

// File: rtl/fdt_drive_timing_chk.sv
module fdt_drive_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic spec_we_i,
  input logic spec_nd_i,
  input logic spec_err_o,
  input logic step_o,
  input logic step_busy_o,
  input logic step_done_o,
  input logic head_load_i,
  input logic head_ready_o,
  input logic rw_end_i,
  input logic head_unload_o
);
  AST_ERR_ON_ND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_we_i && spec_nd_i |=> spec_err_o); // R2
  AST_ERR_ONLY_ND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spec_we_i && spec_nd_i) |=> !spec_err_o); // R2
  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o); // R5
  AST_STEP_IN_SEEK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> step_busy_o); // R5
  AST_DONE_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> !step_o); // R5
  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_load_i |=> !head_ready_o); // R7
  AST_UNLOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_unload_o |=> !head_unload_o); // R8
  AST_UNLOAD_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(head_load_i) && !rw_end_i |=> !head_unload_o); // R8
endmodule

bind fdt_drive_timing fdt_drive_timing_chk i_fdt_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .spec_we_i     (spec_we_i),
  .spec_nd_i     (spec_nd_i),
  .spec_err_o    (spec_err_o),
  .step_o        (step_o),
  .step_busy_o   (step_busy_o),
  .step_done_o   (step_done_o),
  .head_load_i   (head_load_i),
  .head_ready_o  (head_ready_o),
  .rw_end_i      (rw_end_i),
  .head_unload_o (head_unload_o)
);

// File: tb/test_fdt_drive_timing.sv
`timescale 1ns/1ps
module test_fdt_drive_timing;
  localparam int TP = 4;
  localparam int SCW = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tick_i = 1'b0;
  logic [1:0]     rate_i = 2'b11;
  logic           spec_we_i = 1'b0, spec_nd_i = 1'b0;
  logic [3:0]     spec_srt_i = '0;
  logic [6:0]     spec_hlt_i = '0;
  logic [3:0]     spec_hut_i = '0;
  logic           spec_err_o;
  logic           step_req_i = 1'b0, step_dir_i = 1'b0;
  logic [SCW-1:0] step_cnt_i = '0;
  logic           step_o, step_dir_o, step_busy_o, step_done_o;
  logic           head_load_i = 1'b0, head_ready_o;
  logic           rw_end_i = 1'b0, head_unload_o;

  int total = 0, bad = 0, ntick = 0, ph = 0;
  int cur_srt = 0, cur_hlt = 0, cur_hut = 0;

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    ph = (ph + 1) % TP;
    tick_i = (ph == 0);
  end
  always @(posedge clk_i) if (tick_i) ntick++;

  fdt_drive_timing #(.STEP_CNT_W(SCW)) i_fdt_drive_timing (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int rate, input int u);
    case (rate)
      0: return 2 * u;
      1: return (10 * u + 2) / 3;
      2: return 4 * u;
      default: return u;
    endcase
  endfunction

  function automatic int srt_u(input int n); return 16 - n; endfunction
  function automatic int hlt_u(input int n); return n == 0 ? 256 : 2 * n; endfunction
  function automatic int hut_u(input int n); return n == 0 ? 256 : 16 * n; endfunction

  task automatic spec(input int s, input int l, input int u, input bit nd);
    @(negedge clk_i);
    spec_we_i = 1'b1; spec_nd_i = nd;
    spec_srt_i = 4'(s); spec_hlt_i = 7'(l); spec_hut_i = 4'(u);
    @(negedge clk_i);
    spec_we_i = 1'b0; spec_nd_i = 1'b0;
    if (!nd) begin cur_srt = s; cur_hlt = l; cur_hut = u; end
  endtask

  task automatic t_reset;
    chk(!step_o && !step_busy_o && !step_done_o && !head_ready_o &&
        !head_unload_o && !spec_err_o, "R1 outputs idle", 1, 0);
  endtask

  task automatic t_step(input int rate, input int cnt, input bit dir, input bit interfere);
    int t0, pulses, i, gap, e;
    bit fin;
    @(negedge clk_i);
    rate_i = 2'(rate);
    step_req_i = 1'b1; step_dir_i = dir; step_cnt_i = SCW'(cnt);
    @(negedge clk_i);
    step_req_i = 1'b0;
    e = exp_ticks(rate, srt_u(cur_srt));
    if (cnt == 0) begin
      chk(step_done_o && !step_o, "R6 zero count done", step_done_o, 1);
      return;
    end
    chk(step_o == 1'b1, "R5 first pulse", step_o, 1);
    t0 = ntick; pulses = 1; fin = 0; i = 0;
    while (!fin && i < 30000) begin
      if (interfere && i == 0) begin
        step_req_i = 1'b1; step_dir_i = !dir; step_cnt_i = SCW'(cnt + 3);
      end else if (interfere && i == 1) begin
        step_req_i = 1'b0;
      end
      @(negedge clk_i);
      i++;
      if (step_o) begin
        gap = ntick - t0;
        chk(gap == e, "R4 R3 step gap", gap, e);
        chk(step_dir_o == dir, "R5 direction", step_dir_o, dir);
        t0 = ntick; pulses++;
      end
      if (step_done_o) begin
        gap = ntick - t0;
        chk(gap == e, "R5 done after interval", gap, e);
        fin = 1;
      end
    end
    chk(fin && pulses == cnt, interfere ? "R6 busy request ignored" : "R5 pulse count",
        pulses, cnt);
    @(negedge clk_i);
    chk(!step_busy_o, "R5 idle after done", step_busy_o, 0);
  endtask

  task automatic t_hlt(input int rate);
    int t0, i;
    @(negedge clk_i);
    rate_i = 2'(rate);
    head_load_i = 1'b1;
    @(negedge clk_i);
    t0 = ntick; i = 0;
    while (!head_ready_o && i < 30000) begin @(negedge clk_i); i++; end
    chk(head_ready_o && (ntick - t0) == exp_ticks(rate, hlt_u(cur_hlt)),
        "R7 R3 head load delay", ntick - t0, exp_ticks(rate, hlt_u(cur_hlt)));
    head_load_i = 1'b0;
    @(negedge clk_i);
    chk(!head_ready_o, "R7 ready drops", head_ready_o, 0);
  endtask

  task automatic t_hut(input int rate);
    int t0, i;
    @(negedge clk_i);
    rate_i = 2'(rate);
    rw_end_i = 1'b1;
    @(negedge clk_i);
    rw_end_i = 1'b0;
    t0 = ntick; i = 0;
    while (!head_unload_o && i < 30000) begin @(negedge clk_i); i++; end
    chk(head_unload_o && (ntick - t0) == exp_ticks(rate, hut_u(cur_hut)),
        "R8 R3 head unload delay", ntick - t0, exp_ticks(rate, hut_u(cur_hut)));
    @(negedge clk_i);
    chk(!head_unload_o, "R8 single pulse", head_unload_o, 0);
  endtask

  task automatic t_spec_err;
    int t0, i;
    spec(12, 3, 1, 1'b0);
    @(negedge clk_i);
    spec_we_i = 1'b1; spec_nd_i = 1'b1; spec_srt_i = 4'd0;
    @(negedge clk_i);
    spec_we_i = 1'b0; spec_nd_i = 1'b0;
    chk(spec_err_o, "R2 nd flag", spec_err_o, 1);
    @(negedge clk_i);
    chk(!spec_err_o, "R2 flag one cycle", spec_err_o, 0);
    t_step(3, 3, 1'b0, 1'b0); // codes unchanged: 4-unit interval
  endtask

  task automatic t_abort_hlt;
    int i;
    spec(0, 40, 1, 1'b0);
    @(negedge clk_i);
    rate_i = 2'b11; head_load_i = 1'b1;
    repeat (20) @(negedge clk_i);
    head_load_i = 1'b0;
    i = 0;
    repeat (400) begin @(negedge clk_i); if (head_ready_o) i++; end
    chk(i == 0, "R7 abort on drop", i, 0);
  endtask

  task automatic t_hut_restart_cancel;
    int t0, i, seen;
    spec(0, 1, 2, 1'b0);
    @(negedge clk_i);
    rate_i = 2'b11; rw_end_i = 1'b1;
    @(negedge clk_i); rw_end_i = 1'b0;
    repeat (60) @(negedge clk_i);
    rw_end_i = 1'b1;
    @(negedge clk_i); rw_end_i = 1'b0;
    t0 = ntick; i = 0;
    while (!head_unload_o && i < 30000) begin @(negedge clk_i); i++; end
    chk((ntick - t0) == 32, "R8 restart", ntick - t0, 32);
    rw_end_i = 1'b1;
    @(negedge clk_i); rw_end_i = 1'b0;
    repeat (40) @(negedge clk_i);
    head_load_i = 1'b1;
    seen = 0;
    repeat (200) begin @(negedge clk_i); if (head_unload_o) seen++; end
    chk(seen == 0, "R8 cancel on head load", seen, 0);
    head_load_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_midrun_change;
    int t0, i;
    spec(0, 10, 1, 1'b0);
    @(negedge clk_i);
    rate_i = 2'b11; head_load_i = 1'b1;
    @(negedge clk_i);
    t0 = ntick;
    repeat (3) @(negedge clk_i);
    rate_i = 2'b10;
    spec(0, 50, 1, 1'b0);
    i = 0;
    while (!head_ready_o && i < 30000) begin @(negedge clk_i); i++; end
    chk((ntick - t0) == 20, "R9 running delay kept", ntick - t0, 20);
    head_load_i = 1'b0;
    @(negedge clk_i);
    t_hlt(2);
  endtask

  initial begin
    repeat (180000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_step(3, 2, 1'b1, 1'b0);          // R1 default code 0 -> 16 units
    t_spec_err();
    spec(5, 0, 0, 1'b0);
    for (int r = 0; r < 4; r++) begin
      t_step(r, 4, r[0], 1'b0);
      t_hlt(r);
      t_hut(r);
    end
    spec(15, 127, 15, 1'b0);
    t_step(1, 3, 1'b0, 1'b0);
    t_hlt(1);
    t_hut(0);
    spec(8, 7, 3, 1'b0);
    t_step(0, 0, 1'b0, 1'b0);
    t_step(2, 3, 1'b1, 1'b1);
    t_abort_hlt();
    t_hut_restart_cancel();
    t_midrun_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule